// File: doc/BRIEF.md
# Sleep and Wake Power-Mode Controller

This block decides when the part drops into a low-power sleep while the LCD stays lit, and when it comes back. Firmware writes a one-cycle request strobe. The request takes effect only when system power is absent, so the part is running on battery. Once asleep, any of four events brings the part back: the reset pin, expiry of the autowake timer, a press of the debounced push button, or the return of system power.

The controller only produces state and enable signals. Clock gating and supply switching are left to the logic that reads them. The block shows its current mode on a two-bit code and drives an LCD keep-alive enable. It also keeps a sticky record of which events caused the most recent wake. Software clears that record by writing ones to the bits it wants to drop.

All inputs are synchronous to `clk`, and all outputs are registered.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: On synchronous reset `rst`, `mode_o` is 2'b00 (mission), `lcd_keep_o` is 0 and `wake_cause_o` is 4'b0000. This holds even if reset arrives while asleep.
- R2: In mission mode, suppose `sleep_wr` is high, `sys_pwr` is low and no wake event is present. Then at the next clock edge `mode_o` becomes 2'b01 (sleep with LCD) and `lcd_keep_o` becomes 1.
- R3: While `sys_pwr` is high, `sleep_wr` is ignored: `mode_o` stays 2'b00 and `lcd_keep_o` stays 0.
- R4: In sleep, a high `rst_pin` moves `mode_o` to 2'b10 (wake pending) at the next edge and sets `wake_cause_o[0]`.
- R5: In sleep, a high `autowake_tmo` moves `mode_o` to 2'b10 at the next edge and sets `wake_cause_o[1]`.
- R6: In sleep, a high `button` moves `mode_o` to 2'b10 at the next edge and sets `wake_cause_o[2]`.
- R7: In sleep, `sys_pwr` going high moves `mode_o` to 2'b10 at the next edge and sets `wake_cause_o[3]`.
- R8: Wake pending lasts exactly one cycle and is followed by mission. `lcd_keep_o` is 1 only in sleep mode.
- R9: If a wake event is present in mission mode in the same cycle as `sleep_wr`, the part stays in mission. In that case `wake_cause_o` is unchanged.
- R10: When several wake events arrive together in sleep, every matching cause bit is set in the same cycle.
- R11: A `cause_clr_we` pulse clears the cause bits that are 1 in `cause_clr_mask` and leaves the other bits alone. A bit that is set and cleared in the same cycle ends up set.
- R12: In sleep with no wake event, the mode is held and a further `sleep_wr` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| sleep_wr | input | 1 | One-cycle strobe requesting sleep with the LCD on |
| sys_pwr | input | 1 | System power present |
| rst_pin | input | 1 | Reset pin asserted (wake source 0) |
| autowake_tmo | input | 1 | Autowake timer expired (wake source 1) |
| button | input | 1 | Debounced push button pressed (wake source 2) |
| cause_clr_we | input | 1 | Strobe to clear wake cause bits |
| cause_clr_mask | input | 4 | Ones select the cause bits to clear |
| mode_o | output | 2 | 00 mission, 01 sleep with LCD, 10 wake pending |
| lcd_keep_o | output | 1 | LCD keep-alive enable |
| wake_cause_o | output | 4 | Sticky wake cause, one bit per source |

## Verification
Two pairs of functions can fall in the same cycle here.

The first pair is a sleep request and a wake event, both in mission mode. The bench drives the request strobe together with a button press while on battery. It judges the outcome by the mode staying 00 and the cause bits staying the same.

The second pair is a wake that sets a cause bit and a software clear of that same bit. The bench issues a clear of all four bits in the cycle that two sources wake the part. It then expects exactly those two bits set, and any earlier bit gone.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int NUM_SRC = 4;

  // wake source positions in the cause vector
  localparam int SRC_RSTPIN = 0;
  localparam int SRC_TIMER  = 1;
  localparam int SRC_BUTTON = 2;
  localparam int SRC_POWER  = 3;

  typedef enum logic [1:0] {
    M_MISSION = 2'b00,
    M_SLEEP   = 2'b01,
    M_WAKE    = 2'b10
  } pwr_mode_e;
endpackage

// File: rtl/pwr_wake_collect.sv
module pwr_wake_collect
  import pwr_pkg::*;
(
  input  logic               rst_pin,
  input  logic               autowake_tmo,
  input  logic               button,
  input  logic               sys_pwr,
  output logic [NUM_SRC-1:0] wake_vec,
  output logic               wake_any
);
  always_comb begin
    wake_vec             = '0;
    wake_vec[SRC_RSTPIN] = rst_pin;
    wake_vec[SRC_TIMER]  = autowake_tmo;
    wake_vec[SRC_BUTTON] = button;
    wake_vec[SRC_POWER]  = sys_pwr;
    wake_any             = |wake_vec;
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sleep_wr,
  input  logic      sys_pwr,
  input  logic      wake_any,
  output pwr_mode_e mode_q,
  output logic      lcd_keep_q
);
  pwr_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_MISSION: if (sleep_wr && !sys_pwr && !wake_any) mode_d = M_SLEEP;
      M_SLEEP:   if (wake_any) mode_d = M_WAKE;
      M_WAKE:    mode_d = M_MISSION;
      default:   mode_d = M_MISSION;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= M_MISSION;
      lcd_keep_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      lcd_keep_q <= (mode_d == M_SLEEP);
    end
  end

  // sleep is only entered from a battery-powered request
  assert_sleep_on_battery_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SLEEP && $past(mode_q) == M_MISSION) |-> $past(sleep_wr && !sys_pwr));

  assert_wake_pend_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_WAKE) |=> (mode_q == M_MISSION));

  assert_lcd_only_in_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    lcd_keep_q == (mode_q == M_SLEEP));

  assert_wake_leaves_sleep_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_SLEEP && wake_any) |=> (mode_q == M_WAKE));

  assert_wake_beats_request_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_MISSION && wake_any) |=> (mode_q == M_MISSION));
endmodule

// File: rtl/pwr_cause_reg.sv
module pwr_cause_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] cause_q
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) cause_q[k] <= 1'b0;
      else     cause_q[k] <= set_i[k] | (cause_q[k] & ~(clr_we & clr_mask[k]));
    end
  end

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((cause_q & $past(set_i)) == $past(set_i)));

  assert_no_spurious_set_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sleep_wr,
  input  logic               sys_pwr,
  input  logic               rst_pin,
  input  logic               autowake_tmo,
  input  logic               button,
  input  logic               cause_clr_we,
  input  logic [NUM_SRC-1:0] cause_clr_mask,
  output logic [1:0]         mode_o,
  output logic               lcd_keep_o,
  output logic [NUM_SRC-1:0] wake_cause_o
);
  logic [NUM_SRC-1:0] wake_vec;
  logic               wake_any;
  pwr_mode_e          mode_q;
  logic [NUM_SRC-1:0] cause_set;

  pwr_wake_collect u_collect (
    .rst_pin      (rst_pin),
    .autowake_tmo (autowake_tmo),
    .button       (button),
    .sys_pwr      (sys_pwr),
    .wake_vec     (wake_vec),
    .wake_any     (wake_any)
  );

  pwr_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sleep_wr   (sleep_wr),
    .sys_pwr    (sys_pwr),
    .wake_any   (wake_any),
    .mode_q     (mode_q),
    .lcd_keep_q (lcd_keep_o)
  );

  // causes are recorded only for events that end a sleep
  assign cause_set = (mode_q == M_SLEEP) ? wake_vec : '0;

  pwr_cause_reg #(.W(NUM_SRC)) u_cause (
    .clk      (clk),
    .rst      (rst),
    .set_i    (cause_set),
    .clr_we   (cause_clr_we),
    .clr_mask (cause_clr_mask),
    .cause_q  (wake_cause_o)
  );

  assign mode_o = mode_q;

  assert_mission_keeps_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_MISSION && !cause_clr_we) |=> $stable(wake_cause_o));
endmodule

// File: tb/sim_pwr_sleep_ctrl.sv
module sim_pwr_sleep_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_wr = 1'b0, sys_pwr = 1'b1, rst_pin = 1'b0;
  logic       autowake_tmo = 1'b0, button = 1'b0, cause_clr_we = 1'b0;
  logic [3:0] cause_clr_mask = 4'h0;
  logic [1:0] mode_o;
  logic       lcd_keep_o;
  logic [3:0] wake_cause_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pwr_sleep_ctrl u0 (.*);

  // entry fields: sw pw rp tm bt cw mask[4] | mode[2] lcd cause[4]
  localparam int NV = 22;
  localparam logic [16:0] TBL [0:NV-1] = '{
    17'b0_1_0_0_0_0_0000_00_0_0000, // 0  R1 idle on mains
    17'b1_1_0_0_0_0_0000_00_0_0000, // 1  R3 request ignored on mains
    17'b1_0_0_0_0_0_0000_01_1_0000, // 2  R2 request on battery
    17'b0_0_0_0_0_0_0000_01_1_0000, // 3  R12 hold
    17'b1_0_0_0_0_0_0000_01_1_0000, // 4  R12 repeat request
    17'b0_0_0_0_1_0_0000_10_0_0100, // 5  R6 button wake
    17'b0_0_0_0_0_0_0000_00_0_0100, // 6  R8 back to mission
    17'b0_0_0_0_0_1_0100_00_0_0000, // 7  R11 clear
    17'b1_0_0_0_0_0_0000_01_1_0000, // 8  R2
    17'b0_0_0_1_0_0_0000_10_0_0010, // 9  R5 timer wake
    17'b0_0_0_0_0_0_0000_00_0_0010, // 10 R8
    17'b1_0_0_0_0_0_0000_01_1_0010, // 11 R2
    17'b0_0_1_0_0_0_0000_10_0_0011, // 12 R4 reset pin wake
    17'b0_0_0_0_0_0_0000_00_0_0011, // 13 R8
    17'b1_0_0_0_0_0_0000_01_1_0011, // 14 R2
    17'b0_1_0_0_0_0_0000_10_0_1011, // 15 R7 power return
    17'b0_1_0_0_0_0_0000_00_0_1011, // 16 R8
    17'b1_0_0_0_1_0_0000_00_0_1011, // 17 R9 wake beats request
    17'b0_0_0_0_0_1_0011_00_0_1000, // 18 R11 partial clear
    17'b1_0_0_0_0_0_0000_01_1_1000, // 19 R2
    17'b0_0_0_1_1_1_1111_10_0_0110, // 20 R10 R11 two sources, set beats clear
    17'b0_0_0_0_0_0_0000_00_0_0110  // 21 R8
  };
  localparam int REQ [0:NV-1] = '{1,3,2,12,12,6,8,11,2,5,8,2,4,8,2,7,8,9,11,2,10,8};

  task automatic check(input string tag, input logic [1:0] em, input logic el,
                       input logic [3:0] ec);
    total++;
    if (mode_o !== em || lcd_keep_o !== el || wake_cause_o !== ec) begin
      bad++;
      $display("FAIL %s: mode=%b lcd=%b cause=%b expected mode=%b lcd=%b cause=%b",
               tag, mode_o, lcd_keep_o, wake_cause_o, em, el, ec);
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 2'b00, 1'b0, 4'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {sleep_wr, sys_pwr, rst_pin, autowake_tmo, button, cause_clr_we, cause_clr_mask} = TBL[i][16:7];
      @(negedge clk);
      check($sformatf("vec %0d R%0d", i, REQ[i]), TBL[i][6:5], TBL[i][4], TBL[i][3:0]);
    end

    // R1: reset while asleep clears mode, enable and cause
    {sleep_wr, sys_pwr, rst_pin, autowake_tmo, button, cause_clr_we, cause_clr_mask} = '0;
    sleep_wr = 1'b1;
    @(negedge clk);
    sleep_wr = 1'b0;
    check("R2 sleep before reset", 2'b01, 1'b1, 4'b0110);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset from sleep", 2'b00, 1'b0, 4'h0);
    rst = 1'b0;

    // R9: timer expiry in mission does not record a cause
    autowake_tmo = 1'b1;
    sleep_wr = 1'b1;
    @(negedge clk);
    autowake_tmo = 1'b0;
    sleep_wr = 1'b0;
    check("R9 timer with request in mission", 2'b00, 1'b0, 4'h0);

    // R10: all four sources together
    sleep_wr = 1'b1;
    @(negedge clk);
    sleep_wr = 1'b0;
    {sys_pwr, rst_pin, autowake_tmo, button} = 4'b1111;
    @(negedge clk);
    check("R10 all sources", 2'b10, 1'b0, 4'b1111);
    {sys_pwr, rst_pin, autowake_tmo, button} = 4'b0000;
    @(negedge clk);
    check("R8 after all sources", 2'b00, 1'b0, 4'b1111);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule